// File: doc/BRIEF.md
# Peripheral Interrupt Status and DMA Register Decoder

This block sits between a DSP core's 24-bit peripheral bus and the peripherals behind it. It recognises one address as the interrupt status word, which it holds itself. It recognises a run of four consecutive addresses as the registers of a DMA engine. For those four it forwards the read and write strobes, a two-bit register index and the write data. A read of any address the block does not recognise returns a fixed filler word.

The status word holds a frame-abort bit (bit 0) and a frame-start bit (bit 1). Bit 1 is set by an external start-of-frame pulse. Bit 7 is not stored here: it shows, live, the DMA engine's end-of-list level. Software clears status bits by writing ones to them. A one written to bit 7 produces a one-cycle clear pulse back to the DMA engine, which owns that flag.

The bus uses plain strobes. A read or a write is accepted in every cycle its strobe is high, and the block never pushes back. Read data and its valid flag appear one clock after the read strobe. The core must take them in that cycle, because the next read overwrites them.

Top module: `periph_irq_decoder`

## Requirements
- R1: Address 0xFFFFD4, 0xFFFFD5, 0xFFFFD6 and 0xFFFFD7 map to DMA register index 0 (next block), 1 (start block), 2 (control) and 3 (configuration) on `dma_sel`. In the same cycle, `dma_rd` or `dma_wr` follows `bus_rd` or `bus_wr`, and `dma_wdata` equals `bus_wdata`. Any other address raises neither DMA strobe.
- R2: `bus_rvalid` is high exactly in the clock after a cycle with `bus_rd` high. `bus_rdata` is valid in that same clock.
- R3: A read of any address other than 0xFFFFC5 and 0xFFFFD4..0xFFFFD7 returns 0x0ABABA.
- R4: A read of 0xFFFFC5 returns the stored status bits. Bit 7 is also set whenever `dma_eol` was high in the read cycle.
- R5: A write to 0xFFFFC5 clears every stored status bit that is 1 in `bus_wdata`. All other stored bits keep their values.
- R6: A write to 0xFFFFC5 with `bus_wdata` bit 7 set pulses `dma_eol_clr` high in that cycle. No other write raises `dma_eol_clr`.
- R7: A `frame_start` pulse sets status bit 1, and a read in any later cycle shows it.
- R8: When `frame_start` and a status write clearing bit 1 fall in the same cycle, bit 1 ends up set.
- R9: While `rst_n` is low, all stored status bits clear and `bus_rvalid` is low.
- R10: A write to an unmapped address changes no status bit and raises no DMA strobe.
- R11: A read of a DMA register returns the `dma_rdata` value presented in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 24 | Peripheral address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one clock after `bus_rd` |
| frame_start | input | 1 | Start-of-frame pulse, sets status bit 1 |
| dma_eol | input | 1 | DMA end-of-list level |
| dma_eol_clr | output | 1 | Clear pulse for the DMA end-of-list flag |
| dma_sel | output | 2 | DMA register index |
| dma_rd | output | 1 | DMA register read strobe |
| dma_wr | output | 1 | DMA register write strobe |
| dma_wdata | output | 24 | DMA register write data |
| dma_rdata | input | 24 | DMA register read data, combinational |

## Verification
The assertions check the following on every cycle:
- the one-cycle read latency of the valid flag;
- the filler word on unmapped reads;
- that a start-of-frame pulse always leaves bit 1 set;
- that a clear without a competing set drops it;
- that the stored word holds when nothing touches it;
- that the DMA strobes and the clear pulse never appear without a matching bus write or read.

Only the bench's scenarios show the following:
- the exact address-to-index map;
- the merged end-of-list view on reads;
- that writes to unmapped addresses leave the status word untouched, seen through a later read;
- the data path from `dma_rdata`.

// File: rtl/periph_pkg.sv
package periph_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 24;

  localparam logic [ADDR_W-1:0] STATUS_ADDR_D = 24'hFFFFC5;
  localparam logic [ADDR_W-1:0] DMA_BASE_D    = 24'hFFFFD4;
  localparam logic [DATA_W-1:0] FILLER_D      = 24'h0ABABA;

  localparam int BIT_ABORT  = 0;
  localparam int BIT_FSTART = 1;
  localparam int BIT_EOL    = 7;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_STATUS = 2'd1,
    TGT_DMA    = 2'd2
  } tgt_e;
endpackage

// File: rtl/periph_addr_decode.sv
module periph_addr_decode
  import periph_pkg::*;
#(
  parameter int                AW          = ADDR_W,
  parameter logic [AW-1:0]     STATUS_ADDR = STATUS_ADDR_D,
  parameter logic [AW-1:0]     DMA_BASE    = DMA_BASE_D,
  parameter int                DMA_REGS    = 4,
  localparam int               IDX_W       = (DMA_REGS > 1) ? $clog2(DMA_REGS) : 1
) (
  input  logic [AW-1:0]    addr,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] dma_idx
);
  logic [DMA_REGS-1:0] hit;

  for (genvar i = 0; i < DMA_REGS; i++) begin : g_hit
    assign hit[i] = (addr == AW'(DMA_BASE + AW'(i)));
  end

  always_comb begin
    dma_idx = '0;
    for (int i = 0; i < DMA_REGS; i++) begin
      if (hit[i]) dma_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (addr == STATUS_ADDR) tgt = TGT_STATUS;
    else if (|hit)           tgt = TGT_DMA;
    else                     tgt = TGT_NONE;
  end
endmodule

// File: rtl/periph_irq_status.sv
module periph_irq_status
  import periph_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter int SET_BIT = BIT_FSTART,
  parameter int EOL_BIT = BIT_EOL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_pulse,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  input  logic          eol_in,
  output logic [DW-1:0] status_view,
  output logic          eol_clr
);
  logic [DW-1:0] stored_q;
  logic [DW-1:0] stored_d;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] eol_vec;

  assign set_vec = set_pulse ? (DW'(1) << SET_BIT) : '0;
  assign eol_vec = eol_in ? (DW'(1) << EOL_BIT) : '0;

  always_comb begin
    stored_d = stored_q;
    if (clr_en) stored_d = stored_d & ~clr_mask;
    stored_d = stored_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stored_q <= '0;
    else        stored_q <= stored_d;
  end

  assign status_view = stored_q | eol_vec;
  assign eol_clr     = clr_en & clr_mask[EOL_BIT];

  // R7
  sof_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> stored_q[SET_BIT]);

  // R5
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_mask[SET_BIT] && !set_pulse) |=> !stored_q[SET_BIT]);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !set_pulse) |=> $stable(stored_q));
endmodule

// File: rtl/periph_rdata_reg.sv
module periph_rdata_reg
  import periph_pkg::*;
#(
  parameter int            DW     = DATA_W,
  parameter logic [DW-1:0] FILLER = FILLER_D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  tgt_e          tgt,
  input  logic [DW-1:0] status_view,
  input  logic [DW-1:0] dma_rdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] mux;

  always_comb begin
    unique case (tgt)
      TGT_STATUS: mux = status_view;
      TGT_DMA:    mux = dma_rdata;
      default:    mux = FILLER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= mux;
    end
  end

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);

  // R3
  filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && tgt == TGT_NONE) |=> (rdata == FILLER));
endmodule

// File: rtl/periph_irq_decoder.sv
module periph_irq_decoder
  import periph_pkg::*;
#(
  parameter int                AW          = ADDR_W,
  parameter int                DW          = DATA_W,
  parameter logic [AW-1:0]     STATUS_ADDR = STATUS_ADDR_D,
  parameter logic [AW-1:0]     DMA_BASE    = DMA_BASE_D,
  parameter logic [DW-1:0]     FILLER      = FILLER_D,
  parameter int                DMA_REGS    = 4,
  localparam int               IDX_W       = (DMA_REGS > 1) ? $clog2(DMA_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  input  logic             frame_start,
  input  logic             dma_eol,
  output logic             dma_eol_clr,
  output logic [IDX_W-1:0] dma_sel,
  output logic             dma_rd,
  output logic             dma_wr,
  output logic [DW-1:0]    dma_wdata,
  input  logic [DW-1:0]    dma_rdata
);
  tgt_e          tgt;
  logic [DW-1:0] status_view;
  logic          status_wr;

  periph_addr_decode #(
    .AW(AW), .STATUS_ADDR(STATUS_ADDR), .DMA_BASE(DMA_BASE), .DMA_REGS(DMA_REGS)
  ) u_dec (
    .addr(bus_addr), .tgt(tgt), .dma_idx(dma_sel)
  );

  assign status_wr = bus_wr && (tgt == TGT_STATUS);

  periph_irq_status #(.DW(DW), .SET_BIT(BIT_FSTART), .EOL_BIT(BIT_EOL)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_pulse(frame_start), .clr_en(status_wr),
    .clr_mask(bus_wdata), .eol_in(dma_eol), .status_view(status_view),
    .eol_clr(dma_eol_clr)
  );

  periph_rdata_reg #(.DW(DW), .FILLER(FILLER)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .tgt(tgt), .status_view(status_view),
    .dma_rdata(dma_rdata), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  assign dma_rd    = bus_rd && (tgt == TGT_DMA);
  assign dma_wr    = bus_wr && (tgt == TGT_DMA);
  assign dma_wdata = bus_wdata;

  // R10
  dma_wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr |-> bus_wr);

  // R1
  dma_rd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd |-> bus_rd);

  // R6
  eol_clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_eol_clr |-> (bus_wr && bus_wdata[BIT_EOL] && !dma_wr));
endmodule

// File: tb/sim_periph_irq_decoder.sv
module sim_periph_irq_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [23:0] addr = '0, wdata = '0, dmard = '0;
  logic        rd = 0, wr = 0, sof = 0, eol = 0;
  logic [23:0] rdata, dma_wdata;
  logic        rvalid, eol_clr, dma_rd, dma_wr;
  logic [1:0]  dma_sel;

  periph_irq_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .frame_start(sof), .dma_eol(eol), .dma_eol_clr(eol_clr), .dma_sel(dma_sel),
    .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rdata(dmard)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_dma(logic [23:0] a);
    return (a >= 24'hFFFFD4) && (a <= 24'hFFFFD7);
  endfunction

  // behavioural reference model
  logic [23:0] m_irq = '0, m_rd = '0, nxt;
  logic        m_rv = 0;
  string       m_tag = "R2";
  always @(posedge clk) begin
    if (!rst_n) begin
      m_irq <= '0; m_rv <= 0;
    end else begin
      m_rv <= rd;
      if (rd) begin
        if (addr == 24'hFFFFC5) begin
          m_rd <= m_irq | (eol ? 24'h80 : 24'h0); m_tag = "R4";
        end else if (is_dma(addr)) begin
          m_rd <= dmard; m_tag = "R11";
        end else begin
          m_rd <= 24'h0ABABA; m_tag = "R3";
        end
      end
      nxt = m_irq;
      if (wr && addr == 24'hFFFFC5) nxt = nxt & ~wdata;
      if (sof) nxt[1] = 1'b1;
      m_irq <= nxt;
    end
  end

  task automatic step(bit r, bit w, logic [23:0] a, logic [23:0] d, bit s, bit e);
    logic [23:0] off;
    @(negedge clk);
    chk(rvalid === m_rv, rst_n ? "R2" : "R9", {23'd0, rvalid}, {23'd0, m_rv});
    if (m_rv) chk(rdata === m_rd, m_tag, rdata, m_rd);
    rd = r; wr = w; addr = a; wdata = d; sof = s; eol = e;
    dmard = $urandom & 24'hFFFFFF;
    #1;
    off = a - 24'hFFFFD4;
    chk(dma_rd === (r && is_dma(a)), is_dma(a) ? "R1" : "R10", {23'd0, dma_rd}, {23'd0, r && is_dma(a)});
    chk(dma_wr === (w && is_dma(a)), is_dma(a) ? "R1" : "R10", {23'd0, dma_wr}, {23'd0, w && is_dma(a)});
    if (is_dma(a)) chk(dma_sel === off[1:0], "R1", {22'd0, dma_sel}, {22'd0, off[1:0]});
    if (w && is_dma(a)) chk(dma_wdata === d, "R1", dma_wdata, d);
    chk(eol_clr === (w && a == 24'hFFFFC5 && d[7]), "R6", {23'd0, eol_clr}, {23'd0, w && a == 24'hFFFFC5 && d[7]});
  endtask

  task automatic rd_chk(logic [23:0] a, bit e, logic [23:0] exp, string req);
    step(1, 0, a, 0, 0, e);
    @(posedge clk); #2;
    chk(rvalid === 1'b1 && rdata === exp, req, rdata, exp);
  endtask

  task automatic idle();
    step(0, 0, 24'h000000, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=%h expected=%h", 24'h0, 24'h1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    chk(rvalid === 1'b0, "R9", {23'd0, rvalid}, 24'd0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk(24'hFFFFC5, 0, 24'h000000, "R9");
    // R7: start-of-frame sets bit 1
    step(0, 0, 0, 0, 1, 0);
    rd_chk(24'hFFFFC5, 0, 24'h000002, "R7");
    // R4: live end-of-list view
    rd_chk(24'hFFFFC5, 1, 24'h000082, "R4");
    // R10: unmapped write leaves status alone
    step(0, 1, 24'hFFFFC4, 24'hFFFFFF, 0, 0);
    step(0, 1, 24'hFFFFD8, 24'hFFFFFF, 0, 0);
    rd_chk(24'hFFFFC5, 0, 24'h000002, "R10");
    // R5: writing zero in bit 1 keeps it
    step(0, 1, 24'hFFFFC5, 24'hFFFFFD, 0, 1);
    rd_chk(24'hFFFFC5, 0, 24'h000002, "R5");
    // R8: set wins over same-cycle clear
    step(0, 1, 24'hFFFFC5, 24'h000002, 1, 0);
    rd_chk(24'hFFFFC5, 0, 24'h000002, "R8");
    // R5: clear bit 1
    step(0, 1, 24'hFFFFC5, 24'h000002, 0, 0);
    rd_chk(24'hFFFFC5, 0, 24'h000000, "R5");
    // R3 filler
    rd_chk(24'hFFFFD3, 0, 24'h0ABABA, "R3");
    rd_chk(24'h000000, 0, 24'h0ABABA, "R3");
    // R11 / R1 DMA registers
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 24'hFFFFD4 + 24'(i), 0, 0, 0);
      @(posedge clk); #2;
      chk(rdata === m_rd, "R11", rdata, m_rd);
      step(0, 1, 24'hFFFFD4 + 24'(i), 24'h123456 + 24'(i), 0, 0);
    end
    idle();
    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [23:0] a;
      case ($urandom % 8)
        0, 1: a = 24'hFFFFC5;
        2: a = 24'hFFFFD4;
        3: a = 24'hFFFFD5;
        4: a = 24'hFFFFD6;
        5: a = 24'hFFFFD7;
        6: a = (($urandom % 2) != 0) ? 24'hFFFFD3 : 24'hFFFFD8;
        default: a = $urandom & 24'hFFFFFF;
      endcase
      step(($urandom % 2) != 0, ($urandom % 3) == 0, a, $urandom & 24'hFFFFFF,
           ($urandom % 6) == 0, ($urandom % 2) != 0);
    end
    idle();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule